// File: doc/BRIEF.md
# Indirect-Indexed Line Parameter RAM

This block is a 2048-entry RAM of 32-bit words that a host reaches only through a window of two registers. The window has an index register and a data port. The host first writes the index register to choose an entry. It then reads or writes the data port to move a word to or from that entry. The index stays where it is after a data access. To walk through the table, the host rewrites the index each time.

Writing the index register can also arm a start pointer. When the index value that results from the write has its flag bit (bit 11) set, the low 11 bits are copied into a separate start-pointer register. That register drives an output port, so line-timing logic can begin its walk from there. The index register is write-only. A read of it returns zero and raises a sticky error flag.

Reads take one clock. The returned word appears together with a one-cycle valid strobe.

Top module: `line_param_ram`

## Requirements
- R1: A write with `host_sel`=0 updates the index register byte by byte. `host_be[i]` enables bits 8i+7..8i, and a lane whose enable is clear keeps its old value.
- R2: The start pointer takes the low 11 bits of the index value that results from a register-0 write, if bit 11 of that value is 1. In every other cycle the start pointer holds its value.
- R3: A read with `host_sel`=1 returns the RAM entry addressed by the low 11 bits of the index. Bits 11 and above of the index do not take part in addressing.
- R4: A write with `host_sel`=1 updates the entry addressed by the index. Only the byte lanes whose `host_be` bit is set change.
- R5: A read with `host_sel`=0 returns zero and sets `bad_read`. `bad_read` stays set until reset.
- R6: `host_rvalid` is high in exactly the cycle after each read request, and `host_rdata` is valid in that cycle.
- R7: Reads and writes on the data port leave the index unchanged, so repeated data reads return the same entry.
- R8: After reset, the start pointer and the index are zero, and `bad_read` and `host_rvalid` are low. The RAM contents are not initialised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_sel | input | 1 | Register select: 0 = index, 1 = data |
| host_wdata | input | 32 | Write data |
| host_be | input | 4 | Byte enables, one bit per 8-bit lane |
| host_wr | input | 1 | Write strobe |
| host_rd | input | 1 | Read strobe |
| host_rdata | output | 32 | Read data, valid with `host_rvalid` |
| host_rvalid | output | 1 | One-cycle read-data valid strobe |
| start_ptr | output | 11 | Captured start pointer for timing logic |
| bad_read | output | 1 | Sticky flag: the index register was read |

## Verification
The assertions assume that `host_wr` and `host_rd` are never high in the same cycle, and one of them checks this. They also assume that both strobes are clean after reset. The bench drives every access through a single task that raises one strobe for exactly one cycle and returns to idle, so accesses never overlap.

Entries are always written before they are read, because the RAM holds unknown contents after reset.

// File: rtl/lpr_pkg.sv
// Package: shared operation type for the line parameter RAM.
// Assumes: one host strobe per cycle at most.
package lpr_pkg;
    typedef enum logic [2:0] {
        OP_IDLE   = 3'd0,
        OP_IDX_WR = 3'd1,
        OP_IDX_RD = 3'd2,
        OP_DAT_WR = 3'd3,
        OP_DAT_RD = 3'd4
    } lpr_op_e;
endpackage

// File: rtl/lpr_index_reg.sv
// Module: index register with byte-lane merge and start-pointer capture.
// Assumes: wr_en only for register-0 writes; FLAG_BIT lies inside DATA_W.
module lpr_index_reg #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 11
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [DATA_W-1:0]   wdata,
    input  logic [DATA_W/8-1:0] be,
    output logic [ADDR_W-1:0]   ram_addr,
    output logic [ADDR_W-1:0]   start_ptr
);
    localparam int BE_W     = DATA_W / 8;
    localparam int FLAG_BIT = ADDR_W;

    logic [DATA_W-1:0] idx_q;
    logic [DATA_W-1:0] idx_next;
    logic [ADDR_W-1:0] start_q;

    // Merge new bytes into the current index, one lane per enable.
    for (genvar g = 0; g < BE_W; g++) begin : g_lane
        assign idx_next[g*8 +: 8] = be[g] ? wdata[g*8 +: 8] : idx_q[g*8 +: 8];
    end

    // Index register update on register-0 writes.
    always_ff @(posedge clk) begin
        if (!rst_n)     idx_q <= '0;
        else if (wr_en) idx_q <= idx_next;
    end

    // Start pointer capture when the merged index carries the flag bit.
    always_ff @(posedge clk) begin
        if (!rst_n)                           start_q <= '0;
        else if (wr_en && idx_next[FLAG_BIT]) start_q <= idx_next[ADDR_W-1:0];
    end

    assign ram_addr  = idx_q[ADDR_W-1:0];
    assign start_ptr = start_q;

    // R7: without a register-0 write the index never moves.
    assert_idx_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(idx_q));
    // R2: the start pointer holds unless a flagged index write occurs.
    assert_start_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(start_q));
endmodule

// File: rtl/lpr_ram.sv
// Module: single-port RAM with byte-lane writes and a registered read.
// Assumes: rd_en and wr_en are never high together; contents are not reset.
module lpr_ram #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 11
) (
    input  logic                clk,
    input  logic                wr_en,
    input  logic                rd_en,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [DATA_W-1:0]   wdata,
    input  logic [DATA_W/8-1:0] be,
    output logic [DATA_W-1:0]   rdata
);
    localparam int BE_W  = DATA_W / 8;
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Byte-lane write into the addressed entry.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            for (int b = 0; b < BE_W; b++) begin
                if (be[b]) mem[addr][b*8 +: 8] <= wdata[b*8 +: 8];
            end
        end
    end

    // Registered read of the addressed entry.
    always_ff @(posedge clk) begin
        if (rd_en) rdata <= mem[addr];
    end
endmodule

// File: rtl/line_param_ram.sv
// Module: top of the indirect-indexed line parameter RAM.
// Decodes the two-register host window, steers accesses to the index
// register or the RAM, and returns read data one cycle later.
// Assumes: host_wr and host_rd are mutually exclusive.
module line_param_ram #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 11
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                host_sel,
    input  logic [DATA_W-1:0]   host_wdata,
    input  logic [DATA_W/8-1:0] host_be,
    input  logic                host_wr,
    input  logic                host_rd,
    output logic [DATA_W-1:0]   host_rdata,
    output logic                host_rvalid,
    output logic [ADDR_W-1:0]   start_ptr,
    output logic                bad_read
);
    import lpr_pkg::*;

    lpr_op_e           op;
    logic [ADDR_W-1:0] ram_addr;
    logic [DATA_W-1:0] ram_q;
    logic              rvalid_q;
    logic              data_sel_q;
    logic              bad_q;

    // Decode the host strobes into one operation.
    always_comb begin
        op = OP_IDLE;
        if (host_wr)      op = host_sel ? OP_DAT_WR : OP_IDX_WR;
        else if (host_rd) op = host_sel ? OP_DAT_RD : OP_IDX_RD;
    end

    lpr_index_reg #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_index (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (op == OP_IDX_WR),
        .wdata     (host_wdata),
        .be        (host_be),
        .ram_addr  (ram_addr),
        .start_ptr (start_ptr)
    );

    lpr_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ram (
        .clk   (clk),
        .wr_en (op == OP_DAT_WR),
        .rd_en (op == OP_DAT_RD),
        .addr  (ram_addr),
        .wdata (host_wdata),
        .be    (host_be),
        .rdata (ram_q)
    );

    // Read-valid strobe and the source of the returned word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rvalid_q   <= 1'b0;
            data_sel_q <= 1'b0;
        end else begin
            rvalid_q   <= (op == OP_DAT_RD) || (op == OP_IDX_RD);
            data_sel_q <= (op == OP_DAT_RD);
        end
    end

    // Sticky flag for reads of the write-only index register.
    always_ff @(posedge clk) begin
        if (!rst_n)                bad_q <= 1'b0;
        else if (op == OP_IDX_RD)  bad_q <= 1'b1;
    end

    assign host_rdata  = data_sel_q ? ram_q : '0;
    assign host_rvalid = rvalid_q;
    assign bad_read    = bad_q;

    // R6: the bench and assertions rely on one strobe per cycle.
    assert_one_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_wr && host_rd));
    // R6: each read request yields valid data on the next cycle.
    assert_rvalid_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
        host_rd |=> host_rvalid);
    // R6: no valid strobe without a request.
    assert_no_spurious_rvalid_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !host_rd |=> !host_rvalid);
    // R5: a read of the index register returns zero.
    assert_idx_read_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && !host_sel) |=> (host_rdata == '0));
    // R5: the error flag, once set, stays set.
    assert_bad_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        bad_read |=> bad_read);
endmodule

// File: tb/tb_line_param_ram.sv
module tb_line_param_ram;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_sel = 1'b0;
    logic [31:0] host_wdata = '0;
    logic [3:0]  host_be = '0;
    logic        host_wr = 1'b0;
    logic        host_rd = 1'b0;
    logic [31:0] host_rdata;
    logic        host_rvalid;
    logic [10:0] start_ptr;
    logic        bad_read;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    line_param_ram dut (
        .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_wdata(host_wdata),
        .host_be(host_be), .host_wr(host_wr), .host_rd(host_rd),
        .host_rdata(host_rdata), .host_rvalid(host_rvalid),
        .start_ptr(start_ptr), .bad_read(bad_read)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic sel, input logic [31:0] d, input logic [3:0] be);
        @(negedge clk);
        host_sel = sel; host_wdata = d; host_be = be; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0; host_be = '0;
    endtask

    task automatic bus_rd(input logic sel, output logic [31:0] d, output logic v);
        @(negedge clk);
        host_sel = sel; host_rd = 1'b1;
        @(negedge clk);
        d = host_rdata; v = host_rvalid;
        host_rd = 1'b0;
    endtask

    task automatic t_reset();
        check("R8 start_ptr", {21'd0, start_ptr}, 32'd0);
        check("R8 bad_read", {31'd0, bad_read}, 32'd0);
        check("R8 rvalid", {31'd0, host_rvalid}, 32'd0);
    endtask

    task automatic t_basic_data();
        logic [31:0] d; logic v;
        bus_wr(1'b0, 32'd5, 4'hF);
        bus_wr(1'b1, 32'hDEADBEEF, 4'hF);
        bus_wr(1'b0, 32'd6, 4'hF);
        bus_wr(1'b1, 32'h11223344, 4'hF);
        bus_wr(1'b0, 32'd5, 4'hF);
        bus_rd(1'b1, d, v);
        check("R3 entry 5", d, 32'hDEADBEEF);
        check("R6 rvalid on read", {31'd0, v}, 32'd1);
        @(negedge clk);
        check("R6 rvalid drops", {31'd0, host_rvalid}, 32'd0);
        bus_rd(1'b1, d, v);
        check("R7 no auto-increment", d, 32'hDEADBEEF);
        bus_wr(1'b0, 32'd6, 4'hF);
        bus_rd(1'b1, d, v);
        check("R3 entry 6", d, 32'h11223344);
    endtask

    task automatic t_data_byte_en();
        logic [31:0] d; logic v;
        bus_wr(1'b0, 32'd5, 4'hF);
        bus_wr(1'b1, 32'hAABBCCDD, 4'b0101);
        bus_rd(1'b1, d, v);
        check("R4 partial data write", d, 32'hDEBBBEDD);
    endtask

    task automatic t_index_byte_en();
        logic [31:0] d; logic v;
        // index 5 -> lane 1 set to 0x07 gives 0x705, flag bit clear
        bus_wr(1'b0, 32'hFFFF07FF, 4'b0010);
        check("R2 no capture without flag", {21'd0, start_ptr}, 32'd0);
        bus_wr(1'b1, 32'h0BADF00D, 4'hF);
        bus_wr(1'b0, 32'd5, 4'hF);
        bus_rd(1'b1, d, v);
        check("R1 lane merge kept entry 5 apart", d, 32'hDEBBBEDD);
        bus_wr(1'b0, 32'h00000705, 4'hF);
        bus_rd(1'b1, d, v);
        check("R1 merged index 0x705", d, 32'h0BADF00D);
    endtask

    task automatic t_start_ptr();
        logic [31:0] d; logic v;
        bus_wr(1'b0, 32'h00000A3C, 4'hF);
        check("R2 capture 0x23C", {21'd0, start_ptr}, 32'h23C);
        bus_wr(1'b1, 32'h5555AAAA, 4'hF);
        bus_wr(1'b0, 32'h0000023C, 4'hF);
        check("R2 hold without flag", {21'd0, start_ptr}, 32'h23C);
        bus_rd(1'b1, d, v);
        check("R3 upper index bits ignored", d, 32'h5555AAAA);
        bus_rd(1'b1, d, v);
        check("R2 hold across data read", {21'd0, start_ptr}, 32'h23C);
        // lane 1 only: 0x23C -> 0x83C, flag set, start becomes 0x03C
        bus_wr(1'b0, 32'h00000800, 4'b0010);
        check("R2 capture from merged value", {21'd0, start_ptr}, 32'h03C);
    endtask

    task automatic t_bad_read();
        logic [31:0] d; logic v;
        bus_rd(1'b0, d, v);
        check("R5 index read is zero", d, 32'd0);
        check("R6 rvalid on index read", {31'd0, v}, 32'd1);
        check("R5 flag set", {31'd0, bad_read}, 32'd1);
        bus_wr(1'b0, 32'd5, 4'hF);
        bus_rd(1'b1, d, v);
        check("R5 flag sticky", {31'd0, bad_read}, 32'd1);
        check("R7 data after flag", d, 32'hDEBBBEDD);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_basic_data();
        t_data_byte_en();
        t_index_byte_en();
        t_start_ptr();
        t_bad_read();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule